// File: doc/BRIEF.md
# Monitor-Mode Debug Event Unit

This unit sits beside a processor pipeline and watches two address streams: the addresses of instruction fetches and the addresses of data accesses. Software programs a bank of instruction breakpoints, a bank of data watchpoints and a per-vector catch mask. Any enabled entry that matches the current address can cause a debug exception. Exceptions are only raised while monitor mode is selected, so the core keeps running and a handler collects state instead of the core being halted.

Instruction-side causes (breakpoints and vector catches) are signalled on the prefetch-abort request. Data-side causes (watchpoints) are signalled on the data-abort request. Each exception records its cause in a method-of-entry field and in a pair of fault-side flags, which the abort handlers read to decide whether to enter the debug monitor. A single-cycle register port gives software access to the unit. Privilege and the current mode decide which writes are accepted.

Top module: `dbg_event_unit`

## Requirements
- R1: After a synchronous reset, no request output is asserted. The control, fault and vector-catch registers read as zero, so monitor mode is off and the entry field holds 0000.
- R2: While control bit 15 (monitor select) is clear, neither request output is ever asserted, whatever the matching entries.
- R3: A write to the control register (address 0x00) takes effect only when `reg_priv` is high. A write to the vector-catch register (0x01), a breakpoint value (0x10+i) or control (0x18+i), or a watchpoint value (0x20+j) or control (0x28+j) takes effect only when `reg_priv` is high and monitor mode is selected. Any other write is ignored. A read with `reg_priv` low returns zero.
- R4: A breakpoint whose control bit 0 is set matches a fetch whose address bits [31:2] equal those of its value register. The match raises `pabt_dbg` on the clock edge that follows the fetch. A breakpoint with bit 0 clear never matches.
- R5: A watchpoint whose control bit 0 is set matches a data access whose address bits [31:2] equal those of its value register. The match raises `dabt_dbg` on the clock edge that follows the access.
- R6: Bit v of the vector-catch register catches vector index v and raises `pabt_dbg` one cycle later. Catches on index 3 (prefetch abort) and index 4 (data abort) are ignored.
- R7: Each debug exception writes control bits [5:2] with the cause: 0001 breakpoint, 0010 watchpoint, 0011 vector catch. The field holds its value until the next exception.
- R8: Each debug exception rewrites the fault register (0x02). Bit 0 is set for an instruction-side cause and bit 1 for a data-side cause; the other bit is cleared.
- R9: When an instruction-side cause and a watchpoint hit in the same cycle, `pabt_dbg` is asserted first, with cause 0001 or 0011. `dabt_dbg` follows one cycle later with cause 0010. The two requests are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_priv | input | 1 | Access comes from a privileged mode |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| fetch_valid | input | 1 | Instruction fetch address is valid |
| fetch_addr | input | 32 | Instruction fetch address |
| data_valid | input | 1 | Data access address is valid |
| data_addr | input | 32 | Data access address |
| vec_valid | input | 1 | An exception vector is being taken |
| vec_idx | input | 3 | Index of that vector |
| pabt_dbg | output | 1 | Instruction-side debug exception request |
| dabt_dbg | output | 1 | Data-side debug exception request |

## Verification
The bench builds the unit with its default six breakpoints and two watchpoints. This small count lets every entry be swept one by one with all four low-address offsets, plus the first miss address beyond the word, before and after its enable is cleared. All eight vector indices are swept with the whole catch mask set, which exposes the two suppressed abort vectors. The same-cycle collision, the locked registers before monitor mode is selected, and the gated reads are each driven directly, with expected cause codes and fault flags worked out in the bench.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int unsigned XLEN     = 32;
    localparam int unsigned REG_AW   = 6;
    localparam int unsigned NUM_VEC  = 8;
    localparam int unsigned VEC_W    = $clog2(NUM_VEC);
    localparam int unsigned MON_BIT  = 15;
    localparam int unsigned VEC_PABT = 3;
    localparam int unsigned VEC_DABT = 4;

    localparam logic [REG_AW-1:0] A_CTRL  = 6'h00;
    localparam logic [REG_AW-1:0] A_VCAT  = 6'h01;
    localparam logic [REG_AW-1:0] A_FSTAT = 6'h02;
    localparam logic [REG_AW-1:0] A_BVR   = 6'h10;
    localparam logic [REG_AW-1:0] A_BCR   = 6'h18;
    localparam logic [REG_AW-1:0] A_WVR   = 6'h20;
    localparam logic [REG_AW-1:0] A_WCR   = 6'h28;

    typedef enum logic [3:0] {
        MOE_NONE   = 4'd0,
        MOE_BKPT   = 4'd1,
        MOE_WATCH  = 4'd2,
        MOE_VCATCH = 4'd3
    } moe_e;

    typedef struct packed {
        logic   valid;
        moe_e   cause;
        logic   inst_side;
        logic   data_side;
    } dbg_evt_t;

    function automatic logic same_word(input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b);
        return a[XLEN-1:2] == b[XLEN-1:2];
    endfunction

    function automatic logic [REG_AW-1:0] slot(input logic [REG_AW-1:0] base,
                                               input int unsigned idx);
        return base + REG_AW'(idx);
    endfunction

endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp
    import dbg_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input  logic                     valid,
    input  logic [XLEN-1:0]          addr,
    input  logic [N-1:0][XLEN-1:0]   vals,
    input  logic [N-1:0]             en,
    output logic                     hit
);
    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_entry
        assign match[i] = en[i] && same_word(vals[i], addr);
    end

    assign hit = valid && (|match);
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
    import dbg_pkg::*;
#(
    parameter int unsigned NUM_BP = 6,
    parameter int unsigned NUM_WP = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr,
    input  logic                         priv,
    input  logic [REG_AW-1:0]            addr,
    input  logic [XLEN-1:0]              wdata,
    input  dbg_evt_t                     evt,
    output logic                         mon_sel,
    output moe_e                         moe,
    output logic [NUM_VEC-1:0]           vcatch,
    output logic [NUM_BP-1:0][XLEN-1:0]  bvr,
    output logic [NUM_BP-1:0]            bcr_en,
    output logic [NUM_WP-1:0][XLEN-1:0]  wvr,
    output logic [NUM_WP-1:0]            wcr_en,
    output logic [XLEN-1:0]              rdata
);
    logic       unlocked;
    logic [1:0] fstat;

    assign unlocked = wr && priv && mon_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_sel <= 1'b0;
        end else if (wr && priv && addr == A_CTRL) begin
            mon_sel <= wdata[MON_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            moe   <= MOE_NONE;
            fstat <= 2'b00;
        end else if (evt.valid) begin
            moe   <= evt.cause;
            fstat <= {evt.data_side, evt.inst_side};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vcatch <= '0;
        end else if (unlocked && addr == A_VCAT) begin
            vcatch <= wdata[NUM_VEC-1:0];
        end
    end

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        always_ff @(posedge clk) begin
            if (rst) begin
                bvr[i]    <= '0;
                bcr_en[i] <= 1'b0;
            end else if (unlocked) begin
                if (addr == slot(A_BVR, i)) bvr[i]    <= wdata;
                if (addr == slot(A_BCR, i)) bcr_en[i] <= wdata[0];
            end
        end
    end

    for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
        always_ff @(posedge clk) begin
            if (rst) begin
                wvr[j]    <= '0;
                wcr_en[j] <= 1'b0;
            end else if (unlocked) begin
                if (addr == slot(A_WVR, j)) wvr[j]    <= wdata;
                if (addr == slot(A_WCR, j)) wcr_en[j] <= wdata[0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (priv) begin
            if (addr == A_CTRL) begin
                rdata[MON_BIT] = mon_sel;
                rdata[5:2]     = moe;
            end
            if (addr == A_VCAT)  rdata[NUM_VEC-1:0] = vcatch;
            if (addr == A_FSTAT) rdata[1:0]         = fstat;
            for (int i = 0; i < NUM_BP; i++) begin
                if (addr == slot(A_BVR, i)) rdata    = bvr[i];
                if (addr == slot(A_BCR, i)) rdata[0] = bcr_en[i];
            end
            for (int j = 0; j < NUM_WP; j++) begin
                if (addr == slot(A_WVR, j)) rdata    = wvr[j];
                if (addr == slot(A_WCR, j)) rdata[0] = wcr_en[j];
            end
        end
    end
endmodule

// File: rtl/dbg_exc.sv
module dbg_exc
    import dbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mon_sel,
    input  logic     bp_hit,
    input  logic     vc_hit,
    input  logic     wp_hit,
    output dbg_evt_t evt,
    output logic     pabt_q,
    output logic     dabt_q
);
    logic inst_now, data_now, pend_q;

    assign inst_now = mon_sel && (bp_hit || vc_hit);
    assign data_now = mon_sel && (wp_hit || pend_q);

    always_comb begin
        evt           = '0;
        evt.inst_side = inst_now;
        evt.data_side = data_now && !inst_now;
        evt.valid     = inst_now || data_now;
        if (inst_now)      evt.cause = bp_hit ? MOE_BKPT : MOE_VCATCH;
        else if (data_now) evt.cause = MOE_WATCH;
        else               evt.cause = MOE_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pabt_q <= 1'b0;
            dabt_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pabt_q <= inst_now;
            dabt_q <= data_now && !inst_now;
            pend_q <= data_now && inst_now;
        end
    end
endmodule

// File: rtl/dbg_event_unit.sv
module dbg_event_unit
    import dbg_pkg::*;
#(
    parameter int unsigned NUM_BP = 6,
    parameter int unsigned NUM_WP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_priv,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    input  logic              fetch_valid,
    input  logic [XLEN-1:0]   fetch_addr,
    input  logic              data_valid,
    input  logic [XLEN-1:0]   data_addr,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec_idx,
    output logic              pabt_dbg,
    output logic              dabt_dbg
);
    logic                        mon_sel;
    moe_e                        moe;
    logic [NUM_VEC-1:0]          vcatch;
    logic [NUM_BP-1:0][XLEN-1:0] bvr;
    logic [NUM_BP-1:0]           bcr_en;
    logic [NUM_WP-1:0][XLEN-1:0] wvr;
    logic [NUM_WP-1:0]           wcr_en;
    logic                        bp_any, wp_any, vc_any, abort_vec;
    dbg_evt_t                    evt;

    dbg_regs #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .priv(reg_priv), .addr(reg_addr),
        .wdata(reg_wdata), .evt(evt), .mon_sel(mon_sel), .moe(moe),
        .vcatch(vcatch), .bvr(bvr), .bcr_en(bcr_en), .wvr(wvr),
        .wcr_en(wcr_en), .rdata(reg_rdata)
    );

    dbg_cmp #(.N(NUM_BP)) u_bp_cmp (
        .valid(fetch_valid), .addr(fetch_addr), .vals(bvr), .en(bcr_en),
        .hit(bp_any)
    );

    dbg_cmp #(.N(NUM_WP)) u_wp_cmp (
        .valid(data_valid), .addr(data_addr), .vals(wvr), .en(wcr_en),
        .hit(wp_any)
    );

    assign abort_vec = (vec_idx == VEC_W'(VEC_PABT)) || (vec_idx == VEC_W'(VEC_DABT));
    assign vc_any    = vec_valid && vcatch[vec_idx] && !abort_vec;

    dbg_exc u_exc (
        .clk(clk), .rst(rst), .mon_sel(mon_sel), .bp_hit(bp_any),
        .vc_hit(vc_any), .wp_hit(wp_any), .evt(evt),
        .pabt_q(pabt_dbg), .dabt_q(dabt_dbg)
    );
endmodule

// File: rtl/dbg_event_unit_chk.sv
module dbg_event_unit_chk
    import dbg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_priv,
    input logic [REG_AW-1:0] reg_addr,
    input logic              fetch_valid,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_idx,
    input logic              mon_sel,
    input logic [3:0]        moe,
    input logic [NUM_VEC-1:0] vcatch,
    input logic              bp_any,
    input logic              wp_any,
    input logic              pabt_dbg,
    input logic              dabt_dbg
);
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !mon_sel |=> (!pabt_dbg && !dabt_dbg));

    assert_vcatch_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_VCAT && !(reg_priv && mon_sel)) |=> $stable(vcatch));

    assert_bp_request_R4: assert property (@(posedge clk) disable iff (rst)
        (mon_sel && bp_any) |=> pabt_dbg);

    assert_abort_vec_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !fetch_valid && (vec_idx == 3'd3 || vec_idx == 3'd4)) |=> !pabt_dbg);

    assert_inst_cause_R7: assert property (@(posedge clk) disable iff (rst)
        pabt_dbg |-> (moe == MOE_BKPT || moe == MOE_VCATCH));

    assert_data_cause_R7: assert property (@(posedge clk) disable iff (rst)
        dabt_dbg |-> (moe == MOE_WATCH));

    assert_never_both_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pabt_dbg, dabt_dbg}));

    assert_bp_first_R9: assert property (@(posedge clk) disable iff (rst)
        (mon_sel && bp_any && wp_any) |=> (pabt_dbg && !dabt_dbg));
endmodule

bind dbg_event_unit dbg_event_unit_chk i_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_priv(reg_priv),
    .reg_addr(reg_addr), .fetch_valid(fetch_valid), .vec_valid(vec_valid),
    .vec_idx(vec_idx), .mon_sel(mon_sel), .moe(moe), .vcatch(vcatch),
    .bp_any(bp_any), .wp_any(wp_any), .pabt_dbg(pabt_dbg), .dabt_dbg(dabt_dbg)
);

// File: tb/test_dbg_event_unit.sv
`timescale 1ns/1ps
module test_dbg_event_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_priv = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        fetch_valid = 1'b0, data_valid = 1'b0, vec_valid = 1'b0;
    logic [31:0] fetch_addr = '0, data_addr = '0;
    logic [2:0]  vec_idx = '0;
    logic        pabt_dbg, dabt_dbg;
    int          checks = 0, fails = 0;

    always #5 clk = ~clk;

    dbg_event_unit i_dbg_event_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_priv(reg_priv),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .data_valid(data_valid), .data_addr(data_addr),
        .vec_valid(vec_valid), .vec_idx(vec_idx),
        .pabt_dbg(pabt_dbg), .dabt_dbg(dabt_dbg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic p);
        reg_addr = a; reg_wdata = d; reg_priv = p; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_priv = 1'b1;
    endtask

    task automatic rd(input logic [5:0] a, input logic p, output logic [31:0] d);
        reg_addr = a; reg_priv = p;
        #1 d = reg_rdata;
        reg_priv = 1'b1;
    endtask

    // drive one cycle of addresses, return the requests seen one edge later
    task automatic step(input logic fv, input logic [31:0] fa, input logic dv,
                        input logic [31:0] da, input logic vv, input logic [2:0] vi,
                        output logic pa, output logic dq);
        fetch_valid = fv; fetch_addr = fa; data_valid = dv; data_addr = da;
        vec_valid = vv; vec_idx = vi;
        @(negedge clk);
        fetch_valid = 1'b0; data_valid = 1'b0; vec_valid = 1'b0;
        pa = pabt_dbg; dq = dabt_dbg;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic pa, dq;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 pabt", {31'b0, pabt_dbg}, 0);
        chk("R1 dabt", {31'b0, dabt_dbg}, 0);
        rd(6'h00, 1, v); chk("R1 ctrl", v, 0);
        rd(6'h02, 1, v); chk("R1 fault", v, 0);
        rd(6'h01, 1, v); chk("R1 vcatch", v, 0);

        // R3: locked before monitor mode, privilege gating
        wr(6'h11, 32'hABCD_0000, 1); rd(6'h11, 1, v); chk("R3 bvr locked", v, 0);
        wr(6'h00, 32'h0000_8000, 0); rd(6'h00, 1, v); chk("R3 ctrl nonpriv", v, 0);
        wr(6'h00, 32'hFFFF_FFFF, 1); rd(6'h00, 1, v); chk("R3 ctrl priv", v, 32'h8000);
        wr(6'h01, 32'h0000_00FF, 0); rd(6'h01, 1, v); chk("R3 vcatch nonpriv", v, 0);
        rd(6'h00, 0, v); chk("R3 nonpriv read", v, 0);
        wr(6'h11, 32'h1234_5678, 1); rd(6'h11, 1, v); chk("R3 bvr unlocked", v, 32'h1234_5678);

        // R4/R7/R8: sweep every breakpoint
        for (int i = 0; i < 6; i++) begin
            logic [31:0] base;
            base = 32'h1000_0000 + 32'(i) * 32'h140;
            wr(6'h10 + 6'(i), base, 1);
            wr(6'h18 + 6'(i), 32'h1, 1);
            for (int off = 0; off < 4; off++) begin
                step(1, base + 32'(off), 0, 0, 0, 0, pa, dq);
                chk("R4 bp hit", {30'b0, pa, dq}, 32'b10);
            end
            rd(6'h00, 1, v); chk("R7 bp cause", v, 32'h8000 | (32'd1 << 2));
            rd(6'h02, 1, v); chk("R8 inst flag", v, 32'h1);
            step(1, base + 32'd4, 0, 0, 0, 0, pa, dq);
            chk("R4 next word miss", {31'b0, pa}, 0);
            wr(6'h18 + 6'(i), 32'h0, 1);
            step(1, base, 0, 0, 0, 0, pa, dq);
            chk("R4 disabled", {31'b0, pa}, 0);
        end

        // R5/R7/R8: sweep every watchpoint
        for (int j = 0; j < 2; j++) begin
            logic [31:0] base;
            base = 32'h2000_0000 + 32'(j) * 32'h80;
            wr(6'h20 + 6'(j), base, 1);
            wr(6'h28 + 6'(j), 32'h1, 1);
            for (int off = 0; off < 4; off++) begin
                step(0, 0, 1, base + 32'(off), 0, 0, pa, dq);
                chk("R5 wp hit", {30'b0, pa, dq}, 32'b01);
            end
            rd(6'h00, 1, v); chk("R7 wp cause", v, 32'h8000 | (32'd2 << 2));
            rd(6'h02, 1, v); chk("R8 data flag", v, 32'h2);
            step(0, 0, 1, base - 32'd4, 0, 0, pa, dq);
            chk("R5 prev word miss", {31'b0, dq}, 0);
            wr(6'h28 + 6'(j), 32'h0, 1);
        end

        // R6: vector catch on every index
        wr(6'h01, 32'hFF, 1);
        for (int k = 0; k < 8; k++) begin
            step(0, 0, 0, 0, 1, 3'(k), pa, dq);
            chk("R6 vector", {31'b0, pa}, (k == 3 || k == 4) ? 32'd0 : 32'd1);
            if (k == 0) begin
                rd(6'h00, 1, v); chk("R7 vcatch cause", v, 32'h8000 | (32'd3 << 2));
            end
        end
        wr(6'h01, 32'h0, 1);
        step(0, 0, 0, 0, 1, 3'd0, pa, dq);
        chk("R6 mask clear", {31'b0, pa}, 0);

        // R9: breakpoint and watchpoint in the same cycle
        wr(6'h10, 32'h3000_0000, 1); wr(6'h18, 32'h1, 1);
        wr(6'h20, 32'h4000_0000, 1); wr(6'h28, 32'h1, 1);
        step(1, 32'h3000_0000, 1, 32'h4000_0000, 0, 0, pa, dq);
        chk("R9 first", {30'b0, pa, dq}, 32'b10);
        rd(6'h00, 1, v); chk("R9 first cause", v, 32'h8000 | (32'd1 << 2));
        step(0, 0, 0, 0, 0, 0, pa, dq);
        chk("R9 second", {30'b0, pa, dq}, 32'b01);
        rd(6'h00, 1, v); chk("R9 second cause", v, 32'h8000 | (32'd2 << 2));
        rd(6'h02, 1, v); chk("R8 after collision", v, 32'h2);

        // R2: monitor deselected keeps both requests low
        wr(6'h00, 32'h0, 1);
        step(1, 32'h3000_0000, 1, 32'h4000_0000, 0, 0, pa, dq);
        chk("R2 off", {30'b0, pa, dq}, 0);
        step(0, 0, 0, 0, 0, 0, pa, dq);
        chk("R2 off tail", {30'b0, pa, dq}, 0);
        rd(6'h00, 1, v); chk("R2 cause kept", v, 32'd2 << 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule